// File: doc/BRIEF.md
# Five-Stage Interstage Register Chain

This block is the backbone of a simple five-stage integer pipeline: it owns the program counter and the four registers that sit between fetch, decode, execute, memory access and writeback. The combinational units sit outside it and connect through plain ports. These units are the instruction memory, decoder, register file, immediate generator, ALU, branch unit and data memory. Each stage hands its values to the block, and the block moves them one stage forward on every clock edge.

The destination register index, the writeback-source code and the write-enable bit travel down the chain with their own instruction. When an instruction reaches writeback, the index, the enable and the chosen data all belong to that instruction. The block drives them back to the register file's write port, which sits in decode. A taken branch or jump found in execute sends the ALU result back to fetch as the next program counter. Hazard handling, stalls and flushes are not part of the block, so the instructions fed in must already be free of dependencies.

Top module: `pipe_regchain`

## Requirements
- R1: While reset is held and in the first cycle after it: `pc_o` equals the parameter `RESET_PC`, `id_instr_o` holds the no-op word 0x00000013, and `wb_we_o` is 0.
- R2: One cycle after the block shows an instruction at `if_instr_i` with program counter P, it presents that word on `id_instr_o`, P on `id_pc_o`, and P+4 on `id_pc4_o`.
- R3: The values driven on `id_rs1_i`, `id_rs2_i` and `id_imm_i` in decode, and that instruction's program counter, appear on `ex_rs1_o`, `ex_rs2_o`, `ex_imm_o` and `ex_pc_o` one cycle later.
- R4: The ALU result and the source-2 value held in execute appear on `mem_addr_o` and `mem_wdata_o` one cycle later.
- R5: The destination index given with an instruction in decode appears on `wb_rd_o` exactly three cycles later, which is four cycles after that instruction was fetched. This holds while a new instruction enters every cycle.
- R6: The writeback data follows the 2-bit select given in decode: 0 picks the ALU result, 1 picks the load data, 2 picks that instruction's PC+4, and 3 also picks the ALU result.
- R7: `wb_we_o` follows the write-enable given in decode, except that it is 0 whenever `wb_rd_o` is 0.
- R8: Without a redirect in execute, the program counter advances by 4 each cycle.
- R9: When `ex_redirect_i` is 1, the next cycle's `pc_o` equals the `ex_alu_i` value of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Current fetch address |
| if_instr_i | input | 32 | Instruction word read at `pc_o` |
| id_instr_o | output | 32 | Instruction in decode |
| id_pc_o | output | 32 | Program counter of the instruction in decode |
| id_pc4_o | output | 32 | PC+4 of the instruction in decode |
| id_rs1_i | input | 32 | Source-1 value read in decode |
| id_rs2_i | input | 32 | Source-2 value read in decode |
| id_imm_i | input | 32 | Immediate produced in decode |
| id_rd_i | input | 5 | Destination register index |
| id_wbsel_i | input | 2 | Writeback source select |
| id_we_i | input | 1 | Register write enable |
| ex_pc_o | output | 32 | Program counter in execute |
| ex_rs1_o | output | 32 | Source-1 value in execute |
| ex_rs2_o | output | 32 | Source-2 value in execute |
| ex_imm_o | output | 32 | Immediate in execute |
| ex_alu_i | input | 32 | ALU result from execute |
| ex_redirect_i | input | 1 | Branch taken or jump in execute |
| mem_addr_o | output | 32 | ALU result held in memory stage (data address) |
| mem_wdata_o | output | 32 | Store data held in memory stage |
| mem_rdata_i | input | 32 | Data memory read value |
| wb_we_o | output | 1 | Register file write enable |
| wb_rd_o | output | 5 | Register file write index |
| wb_data_o | output | 32 | Register file write data |

## Verification
A fresh random instruction enters the pipeline every cycle, with random operands, ALU results, load data, destination indices and select codes. Every stage therefore holds a different instruction at once. A mix-up between neighbouring instructions, such as an index paired with the wrong data, shows up as a mismatch. Directed records walk the four select codes in a row, so a swapped or missing mux leg stands out. They also write register 0 with the enable set, to separate gating by index from plain pass-through of the enable. Random redirects use targets that are far from PC+4, so a dropped or late redirect is easy to tell from normal stepping.

// File: rtl/pipe_regchain_pkg.sv
package pipe_regchain_pkg;

   typedef enum logic [1:0] {
      WB_FROM_ALU  = 2'd0,
      WB_FROM_LOAD = 2'd1,
      WB_FROM_LINK = 2'd2,
      WB_FROM_RSVD = 2'd3
   } wb_src_e;

   localparam logic [31:0] IDLE_WORD = 32'h0000_0013;

endpackage

// File: rtl/pipe_regchain_fetch.sv
module pipe_regchain_fetch #(
   parameter int unsigned    XLEN      = 32,
   parameter logic [XLEN-1:0] START_PC = '0,
   parameter logic [XLEN-1:0] IDLE_INS = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [XLEN-1:0] word_i,
   input  logic            jump_i,
   input  logic [XLEN-1:0] target_i,
   output logic [XLEN-1:0] pc_o,
   output logic [XLEN-1:0] d_word_o,
   output logic [XLEN-1:0] d_pc_o,
   output logic [XLEN-1:0] d_pc4_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

   logic [XLEN-1:0] pc_q, seq_pc, nxt_pc;

   assign seq_pc = pc_q + STEP;
   assign nxt_pc = jump_i ? target_i : seq_pc;
   assign pc_o   = pc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= START_PC;
         d_word_o <= IDLE_INS;
         d_pc_o   <= '0;
         d_pc4_o  <= '0;
      end else begin
         pc_q     <= nxt_pc;
         d_word_o <= word_i;
         d_pc_o   <= pc_q;
         d_pc4_o  <= seq_pc;
      end
   end

   p_pc_step_r8 : assert property (@(posedge clk) disable iff (rst)
      !jump_i |=> (pc_q == $past(pc_q) + STEP));

   p_redirect_r9 : assert property (@(posedge clk) disable iff (rst)
      jump_i |=> (pc_q == $past(target_i)));

endmodule

// File: rtl/pipe_regchain_stage.sv
module pipe_regchain_stage #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/pipe_regchain_wb.sv
module pipe_regchain_wb
   import pipe_regchain_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned IDX_W       = 5,
   parameter bit          ZERO_REG_RO = 1'b1
) (
   input  logic [1:0]       sel_i,
   input  logic             we_i,
   input  logic [IDX_W-1:0] rd_i,
   input  logic [XLEN-1:0]  alu_i,
   input  logic [XLEN-1:0]  load_i,
   input  logic [XLEN-1:0]  link_i,
   output logic             we_o,
   output logic [IDX_W-1:0] rd_o,
   output logic [XLEN-1:0]  data_o
);
   wb_src_e src;
   assign src  = wb_src_e'(sel_i);
   assign rd_o = rd_i;

   always_comb begin
      unique case (src)
         WB_FROM_LOAD: data_o = load_i;
         WB_FROM_LINK: data_o = link_i;
         default:      data_o = alu_i;
      endcase
   end

   generate
      if (ZERO_REG_RO) begin : g_zero_gate
         assign we_o = we_i && (rd_i != '0);
      end else begin : g_no_gate
         assign we_o = we_i;
      end
   endgenerate
endmodule

// File: rtl/pipe_regchain.sv
module pipe_regchain
   import pipe_regchain_pkg::*;
#(
   parameter int unsigned     XLEN        = 32,
   parameter int unsigned     IDX_W       = 5,
   parameter logic [XLEN-1:0] RESET_PC    = '0,
   parameter logic [XLEN-1:0] NOP_INSTR   = XLEN'(IDLE_WORD),
   parameter bit              ZERO_REG_RO = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [XLEN-1:0]  pc_o,
   input  logic [XLEN-1:0]  if_instr_i,
   output logic [XLEN-1:0]  id_instr_o,
   output logic [XLEN-1:0]  id_pc_o,
   output logic [XLEN-1:0]  id_pc4_o,
   input  logic [XLEN-1:0]  id_rs1_i,
   input  logic [XLEN-1:0]  id_rs2_i,
   input  logic [XLEN-1:0]  id_imm_i,
   input  logic [IDX_W-1:0] id_rd_i,
   input  logic [1:0]       id_wbsel_i,
   input  logic             id_we_i,
   output logic [XLEN-1:0]  ex_pc_o,
   output logic [XLEN-1:0]  ex_rs1_o,
   output logic [XLEN-1:0]  ex_rs2_o,
   output logic [XLEN-1:0]  ex_imm_o,
   input  logic [XLEN-1:0]  ex_alu_i,
   input  logic             ex_redirect_i,
   output logic [XLEN-1:0]  mem_addr_o,
   output logic [XLEN-1:0]  mem_wdata_o,
   input  logic [XLEN-1:0]  mem_rdata_i,
   output logic             wb_we_o,
   output logic [IDX_W-1:0] wb_rd_o,
   output logic [XLEN-1:0]  wb_data_o
);
   localparam int unsigned CTL_W  = 3 + IDX_W;
   localparam int unsigned IDEX_W = CTL_W + 5 * XLEN;
   localparam int unsigned EXMA_W = CTL_W + 3 * XLEN;
   localparam int unsigned MAWB_W = CTL_W + 3 * XLEN;
   localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

   generate
      if (XLEN < 16 || (XLEN % 8) != 0) begin : g_bad_xlen
         $error("pipe_regchain: XLEN must be a byte multiple of at least 16");
      end
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("pipe_regchain: IDX_W out of range");
      end
   endgenerate

   // fetch stage and fetch-to-decode register
   pipe_regchain_fetch #(
      .XLEN(XLEN), .START_PC(RESET_PC), .IDLE_INS(NOP_INSTR)
   ) u_fetch (
      .clk(clk), .rst(rst),
      .word_i(if_instr_i), .jump_i(ex_redirect_i), .target_i(ex_alu_i),
      .pc_o(pc_o),
      .d_word_o(id_instr_o), .d_pc_o(id_pc_o), .d_pc4_o(id_pc4_o)
   );

   // decode-to-execute register
   logic [IDEX_W-1:0] idex_d, idex_q;
   logic              x_we;
   logic [1:0]        x_sel;
   logic [IDX_W-1:0]  x_rd;
   logic [XLEN-1:0]   x_pc4;

   assign idex_d = {id_we_i, id_wbsel_i, id_rd_i, id_pc4_o, id_pc_o,
                    id_rs1_i, id_rs2_i, id_imm_i};

   pipe_regchain_stage #(.W(IDEX_W)) u_idex (
      .clk(clk), .rst(rst), .d(idex_d), .q(idex_q));

   assign {x_we, x_sel, x_rd, x_pc4, ex_pc_o, ex_rs1_o, ex_rs2_o, ex_imm_o} = idex_q;

   // execute-to-memory register
   logic [EXMA_W-1:0] exma_d, exma_q;
   logic              m_we;
   logic [1:0]        m_sel;
   logic [IDX_W-1:0]  m_rd;
   logic [XLEN-1:0]   m_pc4;

   assign exma_d = {x_we, x_sel, x_rd, x_pc4, ex_alu_i, ex_rs2_o};

   pipe_regchain_stage #(.W(EXMA_W)) u_exma (
      .clk(clk), .rst(rst), .d(exma_d), .q(exma_q));

   assign {m_we, m_sel, m_rd, m_pc4, mem_addr_o, mem_wdata_o} = exma_q;

   // memory-to-writeback register
   logic [MAWB_W-1:0] mawb_d, mawb_q;
   logic              w_we;
   logic [1:0]        w_sel;
   logic [IDX_W-1:0]  w_rd;
   logic [XLEN-1:0]   w_pc4, w_alu, w_load;

   assign mawb_d = {m_we, m_sel, m_rd, m_pc4, mem_addr_o, mem_rdata_i};

   pipe_regchain_stage #(.W(MAWB_W)) u_mawb (
      .clk(clk), .rst(rst), .d(mawb_d), .q(mawb_q));

   assign {w_we, w_sel, w_rd, w_pc4, w_alu, w_load} = mawb_q;

   // writeback select, returned to the register file port
   pipe_regchain_wb #(
      .XLEN(XLEN), .IDX_W(IDX_W), .ZERO_REG_RO(ZERO_REG_RO)
   ) u_wb (
      .sel_i(w_sel), .we_i(w_we), .rd_i(w_rd),
      .alu_i(w_alu), .load_i(w_load), .link_i(w_pc4),
      .we_o(wb_we_o), .rd_o(wb_rd_o), .data_o(wb_data_o)
   );

   // cycles since reset, saturating, so the checks below never reach before it
   logic [1:0] warm_q;
   always_ff @(posedge clk) begin
      if (rst)                 warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   p_link_pair_r2 : assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) |-> (id_pc4_o == id_pc_o + STEP));

   p_rd_pairing_r5 : assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd3) |-> (wb_rd_o == $past(id_rd_i, 3)));

   p_x0_silent_r7 : assert property (@(posedge clk) disable iff (rst)
      (ZERO_REG_RO && wb_rd_o == '0) |-> !wb_we_o);

   p_reset_quiet_r1 : assert property (@(posedge clk)
      rst |=> (!wb_we_o && pc_o == RESET_PC && id_instr_o == NOP_INSTR));

endmodule

// File: tb/pipe_regchain_bench.sv
module pipe_regchain_bench;
   localparam int N = 600;
   localparam logic [31:0] RPC = 32'h0000_1000;
   localparam logic [31:0] NOPW = 32'h0000_0013;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_o, if_instr_i, id_instr_o, id_pc_o, id_pc4_o;
   logic [31:0] id_rs1_i, id_rs2_i, id_imm_i;
   logic [4:0]  id_rd_i;
   logic [1:0]  id_wbsel_i;
   logic        id_we_i;
   logic [31:0] ex_pc_o, ex_rs1_o, ex_rs2_o, ex_imm_o, ex_alu_i;
   logic        ex_redirect_i;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic        wb_we_o;
   logic [4:0]  wb_rd_o;
   logic [31:0] wb_data_o;

   always #5 clk = ~clk;

   pipe_regchain #(.RESET_PC(RPC)) u_pipe_regchain (
      .clk(clk), .rst(rst), .pc_o(pc_o), .if_instr_i(if_instr_i),
      .id_instr_o(id_instr_o), .id_pc_o(id_pc_o), .id_pc4_o(id_pc4_o),
      .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i), .id_imm_i(id_imm_i),
      .id_rd_i(id_rd_i), .id_wbsel_i(id_wbsel_i), .id_we_i(id_we_i),
      .ex_pc_o(ex_pc_o), .ex_rs1_o(ex_rs1_o), .ex_rs2_o(ex_rs2_o),
      .ex_imm_o(ex_imm_o), .ex_alu_i(ex_alu_i), .ex_redirect_i(ex_redirect_i),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .wb_we_o(wb_we_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o)
   );

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   logic [31:0] ins_a[N], rs1_a[N], rs2_a[N], imm_a[N], alu_a[N], ld_a[N];
   logic [4:0]  rd_a[N];
   logic [1:0]  sel_a[N];
   logic        we_a[N], red_a[N];
   logic [31:0] pcx[N+8];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] wb_expect(input logic [1:0] s, input logic [31:0] a,
                                             input logic [31:0] l, input logic [31:0] p4);
      case (s)
         2'd1:    return l;
         2'd2:    return p4;
         default: return a;
      endcase
   endfunction

   task automatic drive(input int t);
      int k;
      if_instr_i = (t < N) ? ins_a[t] : NOPW;
      k = t - 1;
      if (k >= 0 && k < N) begin
         id_rs1_i = rs1_a[k]; id_rs2_i = rs2_a[k]; id_imm_i = imm_a[k];
         id_rd_i = rd_a[k]; id_wbsel_i = sel_a[k]; id_we_i = we_a[k];
      end else begin
         id_rs1_i = '0; id_rs2_i = '0; id_imm_i = '0;
         id_rd_i = '0; id_wbsel_i = '0; id_we_i = 1'b0;
      end
      k = t - 2;
      if (k >= 0 && k < N) begin ex_alu_i = alu_a[k]; ex_redirect_i = red_a[k]; end
      else begin ex_alu_i = '0; ex_redirect_i = 1'b0; end
      k = t - 3;
      mem_rdata_i = (k >= 0 && k < N) ? ld_a[k] : '0;
   endtask

   task automatic check(input int t);
      int k;
      chk(pc_o == pcx[t], (t > 2 && red_a[t-3]) ? "R9 pc redirect" : "R8 pc step",
          pc_o, pcx[t]);
      k = t - 1;
      if (k >= 0 && k < N) begin
         chk(id_instr_o == ins_a[k], "R2 id instr", id_instr_o, ins_a[k]);
         chk(id_pc_o == pcx[k], "R2 id pc", id_pc_o, pcx[k]);
         chk(id_pc4_o == pcx[k] + 4, "R2 id pc4", id_pc4_o, pcx[k] + 4);
      end
      k = t - 2;
      if (k >= 0 && k < N) begin
         chk(ex_pc_o == pcx[k], "R3 ex pc", ex_pc_o, pcx[k]);
         chk(ex_rs1_o == rs1_a[k], "R3 ex rs1", ex_rs1_o, rs1_a[k]);
         chk(ex_rs2_o == rs2_a[k], "R3 ex rs2", ex_rs2_o, rs2_a[k]);
         chk(ex_imm_o == imm_a[k], "R3 ex imm", ex_imm_o, imm_a[k]);
      end
      k = t - 3;
      if (k >= 0 && k < N) begin
         chk(mem_addr_o == alu_a[k], "R4 mem addr", mem_addr_o, alu_a[k]);
         chk(mem_wdata_o == rs2_a[k], "R4 mem wdata", mem_wdata_o, rs2_a[k]);
      end
      k = t - 4;
      if (k >= 0 && k < N) begin
         logic [31:0] ed;
         logic        ew;
         ed = wb_expect(sel_a[k], alu_a[k], ld_a[k], pcx[k] + 4);
         ew = we_a[k] && (rd_a[k] != 5'd0);
         chk(wb_rd_o == rd_a[k], "R5 wb index", {27'd0, wb_rd_o}, {27'd0, rd_a[k]});
         chk(wb_data_o == ed, "R6 wb data", wb_data_o, ed);
         chk(wb_we_o == ew, "R7 wb enable", {31'd0, wb_we_o}, {31'd0, ew});
      end
   endtask

   initial begin
      #(5000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < N; i++) begin
         ins_a[i] = $urandom; rs1_a[i] = $urandom; rs2_a[i] = $urandom;
         imm_a[i] = $urandom; alu_a[i] = $urandom & 32'hFFFF_FFFC;
         ld_a[i] = $urandom; rd_a[i] = 5'($urandom);
         sel_a[i] = 2'($urandom); we_a[i] = 1'($urandom);
         red_a[i] = (($urandom % 8) == 0);
      end
      // directed: x0 write with enable set (R7), all four select codes (R6)
      rd_a[5] = 5'd0; we_a[5] = 1'b1; red_a[5] = 1'b0;
      for (int i = 0; i < 4; i++) begin
         sel_a[10+i] = 2'(i); we_a[10+i] = 1'b1; rd_a[10+i] = 5'(i + 7);
         red_a[10+i] = 1'b0;
      end
      rd_a[20] = 5'd31; we_a[20] = 1'b0;
      // expected program counter per cycle
      pcx[0] = RPC;
      for (int t = 0; t < N + 7; t++)
         pcx[t+1] = (t >= 2 && t - 2 < N && red_a[t-2]) ? alu_a[t-2] : pcx[t] + 4;

      drive(-10);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pc_o == RPC, "R1 reset pc", pc_o, RPC);
      chk(id_instr_o == NOPW, "R1 reset instr", id_instr_o, NOPW);
      chk(wb_we_o == 1'b0, "R1 reset we", {31'd0, wb_we_o}, 32'd0);
      @(posedge clk);
      #1 rst = 1'b0;
      for (int t = 0; t < N + 4; t++) begin
         drive(t);
         @(negedge clk);
         check(t);
         @(posedge clk);
         #1;
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule